// File: doc/BRIEF.md
# Fallback-safe reconfiguration sequencer

This block runs inside a factory boot image and decides, once per reset, whether to hand control to an application image. After a start pulse it reads the trigger-condition status register of an external remote-update controller over a simple register bus. The status tells it why the current configuration happened. Only when that value is zero, which means a plain power-up, does it arm the controller and request the application load.

The hand-off is a fixed series of five register writes. They set the application flag, load the application start page, load the watchdog timeout, set the watchdog enable, and then write the reconfigure command. If any status bit is set, for example a recorded fallback, CRC error or watchdog expiry (bits 0, 1, 2 and 4), the block writes nothing and parks. This keeps the factory image in control, so the device stays reachable. Every bus access is bounded by a cycle timeout, and a stuck controller ends the run with an error code instead of hanging the sequencer.

Top module: `recfg_handoff_seq`

## Requirements
- R1: A start pulse while idle raises busy in the next cycle, and the first bus access is a read of the trigger-condition register at address ADR_TRIG.
- R2: When the trigger value read is zero, the block makes exactly five writes, in this order: ADR_MODE←1, ADR_PAGE←APP_PAGE, ADR_WDTO←WD_TIMEOUT, ADR_WDEN←1, ADR_RECFG←1. It then raises done with outcome 2'b00.
- R3: When the trigger value is nonzero (any of bits 0, 1, 2, 3 or 4 set), the block makes no write and raises done with outcome 2'b01.
- R4: A command (bus_read or bus_write) keeps its address, write data and direction unchanged while bus_wait is high. It is accepted at the rising edge where bus_wait is low.
- R5: The trigger value is taken from bus_rdata only in a cycle where bus_rvalid is high after the read was accepted. Data present in other cycles is ignored.
- R6: An access that has not completed TMO_CYC cycles after its command first appears is dropped. When the command stays presented, it is on the bus for exactly TMO_CYC cycles. The block then raises done with outcome 2'b10 and makes no further access.
- R7: Once done is high, done and outcome hold until reset. A later start pulse causes no bus access.
- R8: A start pulse while busy does not restart or repeat the sequence.
- R9: busy and done are never high together, and bus_read or bus_write is only ever high while busy is high.
- R10: After reset busy, done, bus_read and bus_write are low and outcome is 2'b00.
- R11: bus_read and bus_write are never high in the same cycle.
- R12: The watchdog-enable register is written only directly after the watchdog-timeout write, and the reconfigure register only directly after the watchdog-enable write. A timeout on an earlier write therefore leaves both unwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| start | input | 1 | Single-cycle request to run the decision |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Terminal state reached; held until reset |
| outcome | output | 2 | 00 handed off, 01 skipped, 10 bus error; valid while done |
| bus_addr | output | AW | Register address of the current command |
| bus_read | output | 1 | Read command |
| bus_write | output | 1 | Write command |
| bus_wdata | output | DW | Write data |
| bus_wait | input | 1 | High stalls the presented command |
| bus_rdata | input | DW | Read data |
| bus_rvalid | input | 1 | Read data valid |

## Verification
The bench builds the block with TMO_CYC at 64, a non-default application page of 0x0040_0000 and a watchdog timeout of 0x1FFF. With a shorter timeout the stuck-bus cases finish quickly, and their exact cycle count can be measured against TMO_CYC. The non-default page and timeout values show that the written data comes from the parameters rather than from fixed constants. The register-file model stalls each command, delays read data behind garbage values, withholds read data, or stalls one chosen register. Together these reach every abort point and the handshake hold rule.

// File: rtl/handoff_pkg.sv
package handoff_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_TRIG,
    ST_WR_MODE,
    ST_WR_PAGE,
    ST_WR_WDTO,
    ST_WR_WDEN,
    ST_WR_RECFG,
    ST_DONE
  } seq_st_e;

  typedef enum logic [1:0] {
    OUT_HANDED  = 2'b00,
    OUT_SKIPPED = 2'b01,
    OUT_BUSERR  = 2'b10
  } outcome_e;

  typedef enum logic [1:0] {
    M_IDLE,
    M_CMD,
    M_RDATA
  } mst_st_e;

  // Successor of a write step in the fixed hand-off order
  function automatic seq_st_e next_write_step(input seq_st_e s);
    case (s)
      ST_WR_MODE:  return ST_WR_PAGE;
      ST_WR_PAGE:  return ST_WR_WDTO;
      ST_WR_WDTO:  return ST_WR_WDEN;
      ST_WR_WDEN:  return ST_WR_RECFG;
      default:     return ST_DONE;
    endcase
  endfunction

  function automatic logic is_access_step(input seq_st_e s);
    return (s != ST_IDLE) && (s != ST_DONE);
  endfunction

endpackage

// File: rtl/hs_bus_master.sv
module hs_bus_master
  import handoff_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 32,
  parameter int TMO_CYC = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_vld,
  input  logic          cmd_wr,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmp,
  output logic          rd_cmp,
  output logic          tmo,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_read,
  output logic          bus_write,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_wait,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rvalid
);

  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYC - 1);

  mst_st_e       st_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [CW-1:0] cnt_q;
  logic          take;
  logic          wr_cmp;

  assign take   = (st_q == M_IDLE) && cmd_vld;
  assign wr_cmp = (st_q == M_CMD) && wr_q && !bus_wait;
  assign rd_cmp = (st_q == M_RDATA) && bus_rvalid;
  assign cmp    = wr_cmp || rd_cmp;
  assign tmo    = (st_q != M_IDLE) && !cmp && (cnt_q == CNT_LAST);
  assign rdata  = bus_rdata;

  assign bus_read  = (st_q == M_CMD) && !wr_q;
  assign bus_write = (st_q == M_CMD) && wr_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= M_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
    end else begin
      case (st_q)
        M_IDLE: begin
          if (take) begin
            st_q    <= M_CMD;
            wr_q    <= cmd_wr;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
            cnt_q   <= '0;
          end
        end
        M_CMD: begin
          cnt_q <= cnt_q + 1'b1;
          if (tmo)            st_q <= M_IDLE;
          else if (!bus_wait) st_q <= wr_q ? M_IDLE : M_RDATA;
        end
        M_RDATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (rd_cmp || tmo) st_q <= M_IDLE;
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import handoff_pkg::*;
#(
  parameter int            AW         = 4,
  parameter int            DW         = 32,
  parameter logic [AW-1:0] ADR_TRIG   = 'h0,
  parameter logic [AW-1:0] ADR_MODE   = 'h3,
  parameter logic [AW-1:0] ADR_PAGE   = 'h4,
  parameter logic [AW-1:0] ADR_WDTO   = 'h2,
  parameter logic [AW-1:0] ADR_WDEN   = 'h5,
  parameter logic [AW-1:0] ADR_RECFG  = 'h6,
  parameter logic [DW-1:0] APP_PAGE   = 'h0080_0000,
  parameter logic [DW-1:0] WD_TIMEOUT = 'h0000_0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmp,
  input  logic          tmo,
  input  logic [DW-1:0] rdata,
  output logic          cmd_vld,
  output logic          cmd_wr,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    outcome
);

  localparam logic [DW-1:0] ONE = DW'(1);

  seq_st_e  st_q;
  outcome_e out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      out_q <= OUT_HANDED;
    end else begin
      case (st_q)
        ST_IDLE: if (start) st_q <= ST_RD_TRIG;
        ST_RD_TRIG: begin
          if (tmo) begin
            st_q  <= ST_DONE;
            out_q <= OUT_BUSERR;
          end else if (cmp) begin
            if (rdata == '0) begin
              st_q <= ST_WR_MODE;
            end else begin
              st_q  <= ST_DONE;
              out_q <= OUT_SKIPPED;
            end
          end
        end
        ST_DONE: st_q <= ST_DONE;
        default: begin
          if (tmo) begin
            st_q  <= ST_DONE;
            out_q <= OUT_BUSERR;
          end else if (cmp) begin
            st_q <= next_write_step(st_q);
            if (st_q == ST_WR_RECFG) out_q <= OUT_HANDED;
          end
        end
      endcase
    end
  end

  always_comb begin
    cmd_addr  = ADR_TRIG;
    cmd_wdata = '0;
    case (st_q)
      ST_WR_MODE:  begin cmd_addr = ADR_MODE;  cmd_wdata = ONE;        end
      ST_WR_PAGE:  begin cmd_addr = ADR_PAGE;  cmd_wdata = APP_PAGE;   end
      ST_WR_WDTO:  begin cmd_addr = ADR_WDTO;  cmd_wdata = WD_TIMEOUT; end
      ST_WR_WDEN:  begin cmd_addr = ADR_WDEN;  cmd_wdata = ONE;        end
      ST_WR_RECFG: begin cmd_addr = ADR_RECFG; cmd_wdata = ONE;        end
      default: ;
    endcase
  end

  assign cmd_vld = is_access_step(st_q);
  assign cmd_wr  = cmd_vld && (st_q != ST_RD_TRIG);
  assign busy    = is_access_step(st_q);
  assign done    = (st_q == ST_DONE);
  assign outcome = out_q;

endmodule

// File: rtl/recfg_handoff_seq.sv
module recfg_handoff_seq #(
  parameter int            AW         = 4,
  parameter int            DW         = 32,
  parameter int            TMO_CYC    = 256,
  parameter logic [AW-1:0] ADR_TRIG   = 'h0,
  parameter logic [AW-1:0] ADR_MODE   = 'h3,
  parameter logic [AW-1:0] ADR_PAGE   = 'h4,
  parameter logic [AW-1:0] ADR_WDTO   = 'h2,
  parameter logic [AW-1:0] ADR_WDEN   = 'h5,
  parameter logic [AW-1:0] ADR_RECFG  = 'h6,
  parameter logic [DW-1:0] APP_PAGE   = 'h0080_0000,
  parameter logic [DW-1:0] WD_TIMEOUT = 'h0000_0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [1:0]    outcome,
  output logic [AW-1:0] bus_addr,
  output logic          bus_read,
  output logic          bus_write,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_wait,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rvalid
);

  // Internal events, named so that the checker can observe them
  logic          ev_cmp;
  logic          ev_rd_cmp;
  logic          ev_tmo;
  logic [DW-1:0] rd_value;
  logic          cmd_vld;
  logic          cmd_wr;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;

  hs_seq_fsm #(
    .AW(AW), .DW(DW),
    .ADR_TRIG(ADR_TRIG), .ADR_MODE(ADR_MODE), .ADR_PAGE(ADR_PAGE),
    .ADR_WDTO(ADR_WDTO), .ADR_WDEN(ADR_WDEN), .ADR_RECFG(ADR_RECFG),
    .APP_PAGE(APP_PAGE), .WD_TIMEOUT(WD_TIMEOUT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmp(ev_cmp), .tmo(ev_tmo), .rdata(rd_value),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .outcome(outcome)
  );

  hs_bus_master #(
    .AW(AW), .DW(DW), .TMO_CYC(TMO_CYC)
  ) u_mst (
    .clk(clk), .rst_n(rst_n),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmp(ev_cmp), .rd_cmp(ev_rd_cmp), .tmo(ev_tmo), .rdata(rd_value),
    .bus_addr(bus_addr), .bus_read(bus_read), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_wait(bus_wait), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

endmodule

// File: rtl/handoff_chk.sv
module handoff_chk #(
  parameter int            AW        = 4,
  parameter int            DW        = 32,
  parameter logic [AW-1:0] ADR_TRIG  = 'h0,
  parameter logic [AW-1:0] ADR_WDTO  = 'h2,
  parameter logic [AW-1:0] ADR_WDEN  = 'h5,
  parameter logic [AW-1:0] ADR_RECFG = 'h6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [1:0]    outcome,
  input logic [AW-1:0] bus_addr,
  input logic          bus_read,
  input logic          bus_write,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_wait,
  input logic [DW-1:0] bus_rdata,
  input logic          ev_rd_cmp,
  input logic          ev_tmo
);

  logic [AW-1:0] last_wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       last_wr_q <= ADR_TRIG;
    else if (bus_write && !bus_wait)  last_wr_q <= bus_addr;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy && !done && !bus_read && !bus_write && outcome == 2'b00); // R10
  AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |=> bus_read && bus_addr == ADR_TRIG); // R1
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n) (bus_read || bus_write) && bus_wait && !ev_tmo |=> $stable(bus_read) && $stable(bus_write) && $stable(bus_addr) && $stable(bus_wdata)); // R4
  AST_SKIP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) ev_rd_cmp && bus_rdata != '0 |=> done && outcome == 2'b01); // R3
  AST_TMO_ERROR: assert property (@(posedge clk) disable iff (!rst_n) ev_tmo |=> done && outcome == 2'b10 && !bus_read && !bus_write); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) done |=> done && $stable(outcome)); // R7
  AST_START_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done && start |=> !busy && !bus_read && !bus_write); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !(done && busy)); // R9
  AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (bus_read || bus_write) |-> busy); // R9
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bus_read && bus_write)); // R11
  AST_WDEN_ORDER: assert property (@(posedge clk) disable iff (!rst_n) bus_write && !bus_wait && bus_addr == ADR_WDEN |-> last_wr_q == ADR_WDTO); // R12
  AST_RECFG_ORDER: assert property (@(posedge clk) disable iff (!rst_n) bus_write && !bus_wait && bus_addr == ADR_RECFG |-> last_wr_q == ADR_WDEN); // R12

endmodule

bind recfg_handoff_seq handoff_chk #(
  .AW(AW), .DW(DW), .ADR_TRIG(ADR_TRIG), .ADR_WDTO(ADR_WDTO),
  .ADR_WDEN(ADR_WDEN), .ADR_RECFG(ADR_RECFG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .outcome(outcome), .bus_addr(bus_addr), .bus_read(bus_read),
  .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_wait(bus_wait),
  .bus_rdata(bus_rdata), .ev_rd_cmp(ev_rd_cmp), .ev_tmo(ev_tmo)
);

// File: tb/sim_recfg_handoff_seq.sv
`timescale 1ns/1ps
module sim_recfg_handoff_seq;

  localparam int AW  = 4;
  localparam int DW  = 32;
  localparam int TMO = 64;
  localparam logic [AW-1:0] A_TRIG = 4'h0, A_MODE = 4'h3, A_PAGE = 4'h4,
                            A_WDTO = 4'h2, A_WDEN = 4'h5, A_RECFG = 4'h6;
  localparam logic [DW-1:0] PAGE_V = 32'h0040_0000;
  localparam logic [DW-1:0] WDTO_V = 32'h0000_1FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, bus_read, bus_write;
  logic [1:0] outcome;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_wait = 1'b0;
  logic [DW-1:0] bus_rdata = 32'hDEAD_BEEF;
  logic bus_rvalid = 1'b0;

  always #10 clk = ~clk;

  recfg_handoff_seq #(
    .AW(AW), .DW(DW), .TMO_CYC(TMO),
    .ADR_TRIG(A_TRIG), .ADR_MODE(A_MODE), .ADR_PAGE(A_PAGE),
    .ADR_WDTO(A_WDTO), .ADR_WDEN(A_WDEN), .ADR_RECFG(A_RECFG),
    .APP_PAGE(PAGE_V), .WD_TIMEOUT(WDTO_V)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .outcome(outcome), .bus_addr(bus_addr), .bus_read(bus_read),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_wait(bus_wait),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } item_t;

  item_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;

  // register-file model configuration
  int            stall_cfg = 0;
  int            stall_left = 0;
  int            rd_lat = 1;
  int            rd_cnt = 0;
  logic          stuck_rd = 1'b0;
  logic          stuck_wr_en = 1'b0;
  logic [AW-1:0] stuck_wr_a = '0;
  logic          drop_rvalid = 1'b0;
  logic [DW-1:0] trig_val = '0;
  int            cmd_cycles = 0;
  logic          held = 1'b0;
  item_t         held_item;

  task automatic chk(input string req, input logic ok, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_acc(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back('{wr: wr, a: a, d: d});
  endtask

  task automatic expect_handoff();
    expect_acc(1'b0, A_TRIG, '0);
    expect_acc(1'b1, A_MODE, 32'd1);
    expect_acc(1'b1, A_PAGE, PAGE_V);
    expect_acc(1'b1, A_WDTO, WDTO_V);
    expect_acc(1'b1, A_WDEN, 32'd1);
    expect_acc(1'b1, A_RECFG, 32'd1);
  endtask

  // Responder and monitor in one process, all at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_wait = 1'b0;
      bus_rvalid = 1'b0;
      bus_rdata = 32'hDEAD_BEEF;
      rd_cnt = 0;
      held = 1'b0;
    end else begin
      bus_rvalid = 1'b0;
      bus_rdata = 32'hDEAD_BEEF;
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin
          bus_rvalid = 1'b1;
          bus_rdata = trig_val;
        end
      end
      if (bus_read || bus_write) begin
        item_t cur;
        logic stuck;
        cur = '{wr: bus_write, a: bus_addr, d: bus_write ? bus_wdata : '0};
        cmd_cycles++;
        if (!busy) chk("R9", 1'b0, "command while not busy", 0, 1);
        if (bus_read && bus_write) chk("R11", 1'b0, "read and write together", 1, 0);
        if (held) chk("R4", cur == held_item, "command changed under wait", cur, held_item);
        stuck = (bus_read && stuck_rd) || (bus_write && stuck_wr_en && bus_addr == stuck_wr_a);
        if (stuck || stall_left > 0) begin
          bus_wait = 1'b1;
          if (!stuck) stall_left--;
          held = 1'b1;
          held_item = cur;
        end else begin
          bus_wait = 1'b0;
          held = 1'b0;
          stall_left = stall_cfg;
          if (exp_q.size() == 0) begin
            chk("R2", 1'b0, "unexpected access", cur, 0);
          end else begin
            item_t e;
            e = exp_q.pop_front();
            chk(e.wr ? "R2" : "R1", cur == e, "access mismatch", cur, e);
          end
          if (bus_read && !drop_rvalid) rd_cnt = rd_lat;
        end
      end else begin
        bus_wait = 1'b0;
        held = 1'b0;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    stall_cfg = 0; stall_left = 0; rd_lat = 1;
    stuck_rd = 1'b0; stuck_wr_en = 1'b0; drop_rvalid = 1'b0;
    trig_val = '0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
  endtask

  task automatic finish_case(input string req, input logic [1:0] exp_out);
    wait_done();
    chk(req, done == 1'b1, "done", done, 1);
    chk(req, outcome == exp_out, "outcome", outcome, exp_out);
    chk("R9", busy == 1'b0, "busy at done", busy, 0);
    repeat (10) @(negedge clk);
    chk(req, exp_q.size() == 0, "missing accesses", exp_q.size(), 0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R10 reset state
    do_reset();
    chk("R10", !busy && !done && outcome == 2'b00, "reset state", {busy, done, outcome}, 0);
    chk("R10", !bus_read && !bus_write, "bus quiet after reset", {bus_read, bus_write}, 0);

    // R1 R2 clean power-up hand-off, no stalls
    stall_left = stall_cfg;
    expect_handoff();
    pulse_start();
    chk("R1", busy == 1'b1, "busy after start", busy, 1);
    finish_case("R2", 2'b00);

    // R7 start after done has no effect
    pulse_start();
    repeat (20) @(negedge clk);
    chk("R7", done && outcome == 2'b00 && !busy, "terminal hold", {done, outcome, busy}, 4'b1000);

    // R3 each status bit blocks the hand-off
    for (int b = 0; b < 5; b++) begin
      do_reset();
      trig_val = 32'd1 << b;
      expect_acc(1'b0, A_TRIG, '0);
      pulse_start();
      finish_case("R3", 2'b01);
    end

    // R4 R5 stalled commands and late read data behind garbage
    do_reset();
    stall_cfg = 3; stall_left = 3; rd_lat = 5;
    expect_handoff();
    pulse_start();
    finish_case("R5", 2'b00);

    // R8 start pulse during a running sequence
    do_reset();
    stall_cfg = 4; stall_left = 4;
    expect_handoff();
    pulse_start();
    repeat (6) @(negedge clk);
    pulse_start();
    finish_case("R8", 2'b00);

    // R6 read never accepted: on the bus exactly TMO cycles
    do_reset();
    stuck_rd = 1'b1;
    cmd_cycles = 0;
    pulse_start();
    finish_case("R6", 2'b10);
    chk("R6", cmd_cycles == TMO, "stalled command cycles", cmd_cycles, TMO);

    // R6 read accepted but no data returned
    do_reset();
    drop_rvalid = 1'b1;
    expect_acc(1'b0, A_TRIG, '0);
    pulse_start();
    finish_case("R6", 2'b10);

    // R12 stall on timeout write: enable and reconfigure never written
    do_reset();
    stuck_wr_en = 1'b1; stuck_wr_a = A_WDTO;
    expect_acc(1'b0, A_TRIG, '0);
    expect_acc(1'b1, A_MODE, 32'd1);
    expect_acc(1'b1, A_PAGE, PAGE_V);
    pulse_start();
    finish_case("R12", 2'b10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule